// File: doc/BRIEF.md
# Per-Lane Event Counter Bank

This block keeps one event counter for every pairing of a lane-resolved event and a lane of a multi-lane serial link controller. Two families of events are counted: link-layer events (acknowledge and flow-control update packets, nullified and duplicate packets) in group 6, and transaction-type transmit and receive counts in group 7. The link logic supplies them as single-cycle pulse vectors, one bit per event and lane.

Software works through two word registers. The control word holds a packed selector (group, event number, lane) and two command fields. A write to it changes the selector, and its commands then act on the counter that the written selector names, and only on that counter. The data word returns the value of the counter named by the current selector. Each counter wraps and has no saturation. Counting is enabled per counter, so software can arm a small set of counters and leave the rest idle.

Top module: `lane_evt_ctr_bank`

## Requirements
- R1: After reset every counter holds zero and is disabled, and the control word reads back as zero.
- R2: The control word is decoded at byte offset 0x8 and the data word at 0xC. Any other offset reads as zero, and writes to it, or to the data word, change neither the selector nor any counter.
- R3: In the control word, bits 27:24 hold the group, bits 23:16 the event number and bits 11:8 the lane. A read returns these three fields, and bit 7 reads 1 exactly when the selected counter is enabled. All other bits read 0.
- R4: The enable field, bits 4:2, turns the selected counter on with value 3'b011 and off with value 3'b001. Any other value leaves its state unchanged.
- R5: A clear field (bits 1:0) of 2'b01 sets the selected counter to zero and leaves every other counter untouched.
- R6: An enabled counter adds one in each cycle that its pulse is high. A disabled counter holds its value.
- R7: Counters are CNT_W bits wide (32 by default), wrap modulo 2^CNT_W and never saturate. The data word returns the value zero-extended to 32 bits.
- R8: A single write that carries both clear and enable-on leaves the counter at zero and enabled, so that it counts the pulses that follow.
- R9: A selector that names a group other than 6 or 7, an event number at or above that group's event count, or a lane at or above NUM_LANES reads zero from the data word and bit 7. Enable and clear commands written with such a selector are ignored and reach no other counter.
- R10: Group 6 events 0 to G6_EVENTS-1 take their pulses from the group-6 vector, and group 7 events 0 to G7_EVENTS-1 take theirs from the group-7 vector. The pulse for event e on lane l is bit e*NUM_LANES+l of its vector.
- R11: A clear wins over a pulse in the same cycle, and the counter reads zero afterwards. A pulse in the cycle of the write that enables a counter is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| g6_pulse | input | G6_EVENTS*NUM_LANES | Link-layer event pulses, bit e*NUM_LANES+l |
| g7_pulse | input | G7_EVENTS*NUM_LANES | Transaction-type event pulses, bit e*NUM_LANES+l |

## Verification
A control write and an event pulse for the same counter can arrive in the same clock cycle, and the outcome depends on which command the write carries. The bench raises the pulse on the exact cycle the write is captured. For a clear, the counter must read zero and not one. For an enable-on, the counter must also stay at zero, because counting only starts in the cycle after the write. A second case combines clear and enable-on in one write, which must give zero and an enabled counter. Selectors that fall just outside the implemented range are also written with live commands, and the bench confirms that the counters they would otherwise alias to keep their values.

// File: rtl/lec_pkg.sv
package lec_pkg;
  localparam int unsigned CTRL_OFS = 8'h08;
  localparam int unsigned DATA_OFS = 8'h0C;

  localparam int unsigned GRP_LSB   = 24;
  localparam int unsigned EVT_LSB   = 16;
  localparam int unsigned LANE_LSB  = 8;
  localparam int unsigned STAT_BIT  = 7;
  localparam int unsigned ENA_LSB   = 2;
  localparam int unsigned CLR_LSB   = 0;

  localparam logic [2:0] ENA_ON  = 3'b011;
  localparam logic [2:0] ENA_OFF = 3'b001;
  localparam logic [1:0] CLR_GO  = 2'b01;

  localparam logic [3:0] GRP_LINK = 4'd6;
  localparam logic [3:0] GRP_XACT = 4'd7;

  typedef struct packed {
    logic [3:0] grp;
    logic [7:0] evt;
    logic [3:0] lane;
  } sel_t;

  function automatic sel_t unpack_sel(input logic [31:0] w);
    sel_t s;
    s.grp  = w[GRP_LSB +: 4];
    s.evt  = w[EVT_LSB +: 8];
    s.lane = w[LANE_LSB +: 4];
    return s;
  endfunction
endpackage

// File: rtl/lec_sel_decode.sv
module lec_sel_decode
  import lec_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned G6_EVENTS = 7,
  parameter int unsigned G7_EVENTS = 24,
  localparam int unsigned NUM_CNT  = (G6_EVENTS + G7_EVENTS) * NUM_LANES,
  localparam int unsigned IDX_W    = $clog2(NUM_CNT)
) (
  input  sel_t             sel,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    if (int'(sel.lane) < int'(NUM_LANES)) begin
      if (sel.grp == GRP_LINK && int'(sel.evt) < int'(G6_EVENTS)) begin
        valid = 1'b1;
        idx   = IDX_W'(int'(sel.evt) * int'(NUM_LANES) + int'(sel.lane));
      end else if (sel.grp == GRP_XACT && int'(sel.evt) < int'(G7_EVENTS)) begin
        valid = 1'b1;
        idx   = IDX_W'((int'(G6_EVENTS) + int'(sel.evt)) * int'(NUM_LANES)
                       + int'(sel.lane));
      end
    end
  end
endmodule

// File: rtl/lec_cell.sv
module lec_cell #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             cmd_on,
  input  logic             cmd_off,
  input  logic             cmd_clr,
  input  logic             pulse,
  output logic [CNT_W-1:0] count_o,
  output logic             en_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_q, en_d;
  logic             cnt_ce, en_ce;

  always_comb begin
    en_ce  = hit && (cmd_on || cmd_off);
    en_d   = cmd_on;
    cnt_ce = (hit && cmd_clr) || (en_q && pulse);
    cnt_d  = (hit && cmd_clr) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      if (en_ce)  en_q  <= en_d;
    end
  end

  assign count_o = cnt_q;
  assign en_o    = en_q;

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmd_clr) |=> (count_o == '0));
  assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_o && !(hit && cmd_clr)) |=> $stable(count_o));
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && pulse && !(hit && cmd_clr) && (&count_o)) |=> (count_o == '0));
  assert_turn_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmd_on) |=> en_o);
  assert_turn_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cmd_off) |=> !en_o);
endmodule

// File: rtl/lane_evt_ctr_bank.sv
module lane_evt_ctr_bank
  import lec_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned G6_EVENTS = 7,
  parameter int unsigned G7_EVENTS = 24,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned G6_W     = G6_EVENTS * NUM_LANES,
  localparam int unsigned G7_W     = G7_EVENTS * NUM_LANES,
  localparam int unsigned NUM_CNT  = G6_W + G7_W,
  localparam int unsigned IDX_W    = $clog2(NUM_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [G6_W-1:0]   g6_pulse,
  input  logic [G7_W-1:0]   g7_pulse
);
  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // control write decode
  logic wr_ctrl;
  sel_t w_sel, sel_q, sel_d;
  logic w_valid, r_valid;
  logic [IDX_W-1:0] w_idx, r_idx;
  logic cmd_on, cmd_off, cmd_clr;

  always_comb begin
    wr_ctrl = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
    w_sel   = unpack_sel(bus_wdata);
    cmd_on  = bus_wdata[ENA_LSB +: 3] == ENA_ON;
    cmd_off = bus_wdata[ENA_LSB +: 3] == ENA_OFF;
    cmd_clr = bus_wdata[CLR_LSB +: 2] == CLR_GO;
    sel_d   = wr_ctrl ? w_sel : sel_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  lec_sel_decode #(.NUM_LANES(NUM_LANES), .G6_EVENTS(G6_EVENTS), .G7_EVENTS(G7_EVENTS))
    u_wdec (.sel(w_sel), .valid(w_valid), .idx(w_idx));
  lec_sel_decode #(.NUM_LANES(NUM_LANES), .G6_EVENTS(G6_EVENTS), .G7_EVENTS(G7_EVENTS))
    u_rdec (.sel(sel_q), .valid(r_valid), .idx(r_idx));

  // counter array
  logic [NUM_CNT-1:0] all_pulse, hit_vec, en_vec;
  logic [CNT_W-1:0]   cnt_arr [NUM_CNT];
  assign all_pulse = {g7_pulse, g6_pulse};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cell
    assign hit_vec[i] = wr_ctrl && w_valid && (w_idx == IDX_W'(i));
    lec_cell #(.CNT_W(CNT_W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_s),
      .hit     (hit_vec[i]),
      .cmd_on  (cmd_on),
      .cmd_off (cmd_off),
      .cmd_clr (cmd_clr),
      .pulse   (all_pulse[i]),
      .count_o (cnt_arr[i]),
      .en_o    (en_vec[i])
    );
  end

  // read path
  logic [31:0] ctrl_word, data_word;
  always_comb begin
    ctrl_word = '0;
    ctrl_word[GRP_LSB +: 4]  = sel_q.grp;
    ctrl_word[EVT_LSB +: 8]  = sel_q.evt;
    ctrl_word[LANE_LSB +: 4] = sel_q.lane;
    ctrl_word[STAT_BIT]      = r_valid && en_vec[r_idx];
    data_word = '0;
    if (r_valid) data_word[CNT_W-1:0] = cnt_arr[r_idx];
    if (bus_addr == ADDR_W'(CTRL_OFS))      bus_rdata = ctrl_word;
    else if (bus_addr == ADDR_W'(DATA_OFS)) bus_rdata = data_word;
    else                                    bus_rdata = '0;
  end

  assert_invalid_zero_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_addr == ADDR_W'(DATA_OFS) && !r_valid) |-> (bus_rdata == '0));
  assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(hit_vec));
  assert_bad_sel_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_ctrl && !w_valid) |-> (hit_vec == '0));
  assert_other_addr_zero_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (bus_addr != ADDR_W'(CTRL_OFS) && bus_addr != ADDR_W'(DATA_OFS)) |-> (bus_rdata == '0));
endmodule

// File: tb/lane_evt_ctr_bank_tb.sv
module lane_evt_ctr_bank_tb_top;
  localparam int L = 4, E6 = 7, E7 = 24;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_w;
  logic [E6*L-1:0] g6 = '0;
  logic [E7*L-1:0] g7 = '0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  lane_evt_ctr_bank dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .g6_pulse(g6), .g7_pulse(g7));
  lane_evt_ctr_bank #(.CNT_W(8)) dut_w (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_w), .g6_pulse(g6), .g7_pulse(g7));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input int g, input int e, input int ln,
                                     input logic [2:0] en, input logic [1:0] clr);
    return {4'h0, 4'(g), 8'(e), 4'h0, 4'(ln), 3'b000, en, clr};
  endfunction

  function automatic logic [31:0] rb(input int g, input int e, input int ln, input logic st);
    return {4'h0, 4'(g), 8'(e), 4'h0, 4'(ln), st, 7'b0};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = rdata;
  endtask

  task automatic set_pulse(input int g, input int e, input int ln, input logic v);
    if (g == 6) g6[e*L+ln] = v; else g7[e*L+ln] = v;
  endtask

  task automatic pulse(input int g, input int e, input int ln, input int n);
    @(negedge clk); set_pulse(g, e, ln, 1'b1);
    repeat (n) @(negedge clk);
    set_pulse(g, e, ln, 1'b0);
  endtask

  task automatic read_cnt(input int g, input int e, input int ln, output logic [31:0] d);
    wr(8'h08, cw(g, e, ln, 3'b000, 2'b00));
    rd(8'h0C, d);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h08, d); check("R1 ctrl after reset", d, 32'h0);
    read_cnt(6, 0, 0, d); check("R1 counter after reset", d, 0);
    rd(8'h08, d); check("R1 disabled after reset", d, rb(6, 0, 0, 1'b0));
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr(8'h08, cw(6, 2, 1, 3'b011, 2'b00));
    pulse(6, 2, 1, 5);
    rd(8'h0C, d); check("R6 count of five", d, 5);
    rd(8'h08, d); check("R3 readback with status", d, rb(6, 2, 1, 1'b1));
    read_cnt(6, 2, 0, d); check("R10 neighbour lane untouched", d, 0);
    wr(8'h08, cw(7, 16, 3, 3'b011, 2'b00));
    pulse(7, 16, 3, 4);
    rd(8'h0C, d); check("R10 group 7 indexing", d, 4);
  endtask

  task automatic t_off;
    logic [31:0] d;
    wr(8'h08, cw(6, 2, 1, 3'b001, 2'b00));
    pulse(6, 2, 1, 3);
    rd(8'h0C, d); check("R6 disabled holds", d, 5);
    wr(8'h08, cw(6, 2, 1, 3'b111, 2'b00));
    rd(8'h08, d); check("R4 other code keeps off", d, rb(6, 2, 1, 1'b0));
    wr(8'h08, cw(7, 16, 3, 3'b010, 2'b00));
    rd(8'h08, d); check("R4 other code keeps on", d, rb(7, 16, 3, 1'b1));
  endtask

  task automatic t_clear;
    logic [31:0] d;
    wr(8'h08, cw(7, 16, 3, 3'b000, 2'b01));
    rd(8'h0C, d); check("R5 selected cleared", d, 0);
    read_cnt(6, 2, 1, d); check("R5 other counter kept", d, 5);
  endtask

  task automatic t_clr_en;
    logic [31:0] d;
    wr(8'h08, cw(6, 2, 1, 3'b011, 2'b01));
    rd(8'h0C, d); check("R8 clear with enable gives zero", d, 0);
    rd(8'h08, d); check("R8 enabled after combined write", d, rb(6, 2, 1, 1'b1));
    pulse(6, 2, 1, 2);
    rd(8'h0C, d); check("R8 counts after restart", d, 2);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = cw(6, 2, 1, 3'b000, 2'b01);
    set_pulse(6, 2, 1, 1'b1);
    @(negedge clk); bus_wr = 1'b0; set_pulse(6, 2, 1, 1'b0);
    rd(8'h0C, d); check("R11 clear beats pulse", d, 0);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = cw(7, 1, 0, 3'b011, 2'b00);
    set_pulse(7, 1, 0, 1'b1);
    @(negedge clk); bus_wr = 1'b0; set_pulse(7, 1, 0, 1'b0);
    rd(8'h0C, d); check("R11 pulse in enabling cycle not counted", d, 0);
  endtask

  task automatic t_invalid;
    logic [31:0] d;
    wr(8'h08, cw(6, 3, 0, 3'b011, 2'b00)); pulse(6, 3, 0, 3);
    wr(8'h08, cw(6, 3, 0, 3'b001, 2'b00));
    wr(8'h08, cw(7, 0, 0, 3'b011, 2'b00)); pulse(7, 0, 0, 6);
    wr(8'h08, cw(7, 0, 0, 3'b001, 2'b00));
    wr(8'h08, cw(6, 2, 4, 3'b011, 2'b01));
    rd(8'h0C, d); check("R9 bad lane reads zero", d, 0);
    rd(8'h08, d); check("R9 bad lane status zero", d, rb(6, 2, 4, 1'b0));
    wr(8'h08, cw(6, 7, 0, 3'b011, 2'b01));
    wr(8'h08, cw(5, 0, 0, 3'b011, 2'b01));
    rd(8'h0C, d); check("R9 bad group reads zero", d, 0);
    read_cnt(6, 3, 0, d); check("R9 alias of bad lane kept", d, 3);
    rd(8'h08, d); check("R9 alias of bad lane still off", d, rb(6, 3, 0, 1'b0));
    read_cnt(7, 0, 0, d); check("R9 alias of bad event kept", d, 6);
  endtask

  task automatic t_addr;
    logic [31:0] d;
    rd(8'h04, d); check("R2 unmapped offset reads zero", d, 0);
    wr(8'h0C, cw(7, 5, 2, 3'b011, 2'b01));
    rd(8'h08, d); check("R2 data write keeps selector", d, rb(7, 0, 0, 1'b0));
    wr(8'h10, cw(7, 0, 0, 3'b000, 2'b01));
    rd(8'h0C, d); check("R2 unmapped write ignored", d, 6);
  endtask

  task automatic t_wrap;
    logic [31:0] d;
    wr(8'h08, cw(6, 0, 0, 3'b011, 2'b01));
    pulse(6, 0, 0, 256);
    @(negedge clk); bus_addr = 8'h0C; #1 d = rdata_w;
    check("R7 8-bit counter wraps to zero", d, 0);
    pulse(6, 0, 0, 1);
    @(negedge clk); bus_addr = 8'h0C; #1 d = rdata_w;
    check("R7 counts on after wrap", d, 1);
    #1 d = rdata; check("R7 wide counter no wrap", d, 257);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset; t_count; t_off; t_clear; t_clr_en;
    t_same_cycle; t_invalid; t_addr; t_wrap;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule